// File: doc/BRIEF.md
# Group Fault and Interrupt Propagation Matrix

This block sits between a power manager and four converter groups, A to D. Each group shares one open-drain OK line. The block senses each line's level and drives a pull-down enable for it. When another party pulls a group's line low, the block uses a programmable group-to-group routing matrix to latch pull-downs on the target groups. Each latched pull-down stays set until the source line is high again and a clear strobe arrives.

The block also reads an active-low status byte for each group and sorts it into warning, fault and error flags. A propagation raised by a group that is in error also marks its targets for fast turn-off, while a fault gives a regular turn-off. Per-group error codes can escalate an error to a front-end disable, or to a front-end disable plus a crowbar request. Four active-low interrupt inputs map, through two registers, to per-group temporary turn-off requests. All configuration goes through a small synchronous write port with a combinational read-back.

Top module: `grp_fault_matrix`

## Requirements
- R1: After reset, every register reads 0. No pull-down, fast-off or interrupt turn-off is active. `fe_en_o` is 1 and `cb_o` is 0.
- R2: Register map:
  - Address 0 is routing register 1. Only the bits in mask 0xDE are writable.
  - Address 1 is routing register 2. Only the bits in mask 0x7B are writable.
  - Address 2 is the error-code register.
  - Addresses 3 and 4 are interrupt maps 1 and 2.
  - Unimplemented bits and unused addresses 5 to 7 read 0, and writes to them have no effect.
- R3: Routing bits, with groups indexed A=0 to D=3:
  - Routing register 1: bit1 A→B, bit2 A→C, bit3 A→D, bit4 B→A, bit6 B→C, bit7 B→D.
  - Routing register 2: bit0 C→A, bit1 C→B, bit3 C→D, bit4 D→A, bit5 D→B, bit6 D→C.
  - A source line pulled low externally sets `ok_pd_o` for every enabled target one clock later.
- R4: A line counts as an external source only while it is low and the block is not driving it. A line the block pulls low never propagates further.
- R5: A latched pull-down holds. It clears on a `clr_i` clock only when its source line reads high at that clock.
- R6: Status byte `grp_stat_i[8g+7:8g]` is active low:
  - `warn_o[g]` is set when bit 7 or bit 6 is 0.
  - `fault_o[g]` is set when any of bits 5 to 2 is 0.
  - `err_o[g]` is set when bit 1 or bit 0 is 0.
- R7: A propagation latched while the source group shows an error also sets `fast_off_o` for the target. A propagation from a source without an error leaves `fast_off_o` at 0.
- R8: The error-code register holds 2 bits per group, with group g at bits [2g+1:2g]. While group g is in error, the outputs follow one clock later:
  - Code 01 drives `fe_en_o` to 0.
  - Code 10 drives `fe_en_o` to 0 and `cb_o` to 1.
  - Codes 00 and 11 have no effect.
- R9: Interrupt map bit 4i+g sits in {map2, map1}. While `int_ni[i]` is low and its map bit for group g is set, `int_off_o[g]` is 1 one clock later. This covers interrupts 0 and 1 in map 1 and interrupts 2 and 3 in map 2, with each nibble ordered D,C,B,A from high to low.
- R10: When all interrupts are released, `int_off_o` returns to 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| clr_i | input | 1 | Clear strobe for latched pull-downs |
| ok_in_i | input | 4 | Sensed OK line levels, bit g is group g |
| ok_pd_o | output | 4 | OK line pull-down enables |
| fast_off_o | output | 4 | Propagated pull-down comes from an error source |
| grp_stat_i | input | 32 | Active-low status byte per group |
| warn_o | output | 4 | Warning flag per group |
| fault_o | output | 4 | Fault flag per group |
| err_o | output | 4 | Error flag per group |
| fe_en_o | output | 1 | Front-end enable, low to disable |
| cb_o | output | 1 | Crowbar request |
| int_ni | input | 4 | Active-low interrupt inputs |
| int_off_o | output | 4 | Interrupt turn-off request per group |

## Verification
The hardest situation to reach is one where a group's line is low only because the block itself drives it. That group must be neither treated as a new source nor released by a single clear. The bench closes the loop with a line model in which each sensed level is low whenever the block or the bench pulls it. It then sets up a chain and a two-sided case. In the chain, A routes to B and B routes to C; C must stay high. In the two-sided case, C drives A while A is also a source; clearing then takes one strobe per stage, because A's own latch can clear only once C's pull-down on A has been released.

// File: rtl/grp_pkg.sv
package grp_pkg;
  localparam int NG     = 4;
  localparam int DW     = 8;
  localparam int AW     = 3;
  localparam int STW    = 8;
  localparam int NRT    = NG * NG;
  localparam int CODE_W = 2;

  localparam logic [AW-1:0] ADR_RT1 = 3'd0;
  localparam logic [AW-1:0] ADR_RT2 = 3'd1;
  localparam logic [AW-1:0] ADR_ERC = 3'd2;
  localparam logic [AW-1:0] ADR_IM1 = 3'd3;
  localparam logic [AW-1:0] ADR_IM2 = 3'd4;

  // diagonal (self-route) positions are the unimplemented bits
  localparam logic [DW-1:0] RT1_MASK = 8'hDE;
  localparam logic [DW-1:0] RT2_MASK = 8'h7B;

  localparam logic [CODE_W-1:0] ERC_FE    = 2'b01;
  localparam logic [CODE_W-1:0] ERC_FE_CB = 2'b10;
endpackage

// File: rtl/grp_cfg_regs.sv
module grp_cfg_regs
  import grp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] rt1_o,
  output logic [DW-1:0] rt2_o,
  output logic [DW-1:0] erc_o,
  output logic [DW-1:0] im1_o,
  output logic [DW-1:0] im2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt1_o <= '0;
      rt2_o <= '0;
      erc_o <= '0;
      im1_o <= '0;
      im2_o <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADR_RT1: rt1_o <= wdata_i & RT1_MASK;
        ADR_RT2: rt2_o <= wdata_i & RT2_MASK;
        ADR_ERC: erc_o <= wdata_i;
        ADR_IM1: im1_o <= wdata_i;
        ADR_IM2: im2_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADR_RT1: rdata_o = rt1_o;
      ADR_RT2: rdata_o = rt2_o;
      ADR_ERC: rdata_o = erc_o;
      ADR_IM1: rdata_o = im1_o;
      ADR_IM2: rdata_o = im2_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/grp_route_core.sv
module grp_route_core
  import grp_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [NRT-1:0] route_i,   // bit s*NG+t enables s -> t
  input  logic [NG-1:0]  ok_in_i,
  input  logic [NG-1:0]  err_src_i,
  output logic [NG-1:0]  pd_o,
  output logic [NG-1:0]  fast_o
);
  logic [NRT-1:0] lat_q, fst_q;
  logic [NG-1:0]  ext_low;

  assign ext_low = ~ok_in_i & ~pd_o;

  for (genvar s = 0; s < NG; s++) begin : g_src
    for (genvar t = 0; t < NG; t++) begin : g_tgt
      localparam int I = s * NG + t;
      if (s != t) begin : g_lat
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            lat_q[I] <= 1'b0;
            fst_q[I] <= 1'b0;
          end else if (route_i[I] && ext_low[s]) begin
            lat_q[I] <= 1'b1;
            fst_q[I] <= fst_q[I] | err_src_i[s];
          end else if (clr_i && ok_in_i[s]) begin
            lat_q[I] <= 1'b0;
            fst_q[I] <= 1'b0;
          end
        end
      end else begin : g_self
        assign lat_q[I] = 1'b0;
        assign fst_q[I] = 1'b0;
      end
    end
  end

  always_comb begin
    pd_o   = '0;
    fast_o = '0;
    for (int s = 0; s < NG; s++) begin
      for (int t = 0; t < NG; t++) begin
        pd_o[t]   = pd_o[t]   | lat_q[s*NG+t];
        fast_o[t] = fast_o[t] | (lat_q[s*NG+t] & fst_q[s*NG+t]);
      end
    end
  end
endmodule

// File: rtl/grp_escalate.sv
module grp_escalate
  import grp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NG*STW-1:0] stat_i,
  input  logic [DW-1:0]     erc_i,
  output logic [NG-1:0]     warn_o,
  output logic [NG-1:0]     fault_o,
  output logic [NG-1:0]     err_o,
  output logic              fe_en_o,
  output logic              cb_o
);
  logic [NG-1:0] fe_req, cb_req;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [STW-1:0]    st;
    logic [CODE_W-1:0] code;
    assign st         = stat_i[g*STW +: STW];
    assign code       = erc_i[g*CODE_W +: CODE_W];
    assign warn_o[g]  = ~&st[7:6];
    assign fault_o[g] = ~&st[5:2];
    assign err_o[g]   = ~&st[1:0];
    assign fe_req[g]  = err_o[g] & ((code == ERC_FE) | (code == ERC_FE_CB));
    assign cb_req[g]  = err_o[g] & (code == ERC_FE_CB);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fe_en_o <= 1'b1;
      cb_o    <= 1'b0;
    end else begin
      fe_en_o <= ~|fe_req;
      cb_o    <= |cb_req;
    end
  end
endmodule

// File: rtl/grp_intr_map.sv
module grp_intr_map
  import grp_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NG-1:0]  int_ni,
  input  logic [NRT-1:0] map_i,   // bit i*NG+g maps interrupt i to group g
  output logic [NG-1:0]  off_o
);
  logic [NG-1:0] off_d;

  always_comb begin
    off_d = '0;
    for (int i = 0; i < NG; i++)
      for (int g = 0; g < NG; g++)
        off_d[g] = off_d[g] | (map_i[i*NG+g] & ~int_ni[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_o <= '0;
    else         off_o <= off_d;
  end
endmodule

// File: rtl/grp_fault_matrix.sv
module grp_fault_matrix
  import grp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              clr_i,
  input  logic [NG-1:0]     ok_in_i,
  output logic [NG-1:0]     ok_pd_o,
  output logic [NG-1:0]     fast_off_o,
  input  logic [NG*STW-1:0] grp_stat_i,
  output logic [NG-1:0]     warn_o,
  output logic [NG-1:0]     fault_o,
  output logic [NG-1:0]     err_o,
  output logic              fe_en_o,
  output logic              cb_o,
  input  logic [NG-1:0]     int_ni,
  output logic [NG-1:0]     int_off_o
);
  logic [DW-1:0] rt1, rt2, erc, im1, im2;

  grp_cfg_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .rt1_o(rt1), .rt2_o(rt2), .erc_o(erc), .im1_o(im1), .im2_o(im2)
  );

  // register bit positions coincide with source*NG+target
  grp_route_core i_route (
    .clk_i, .rst_ni, .clr_i,
    .route_i  ({rt2, rt1}),
    .ok_in_i,
    .err_src_i(err_o),
    .pd_o     (ok_pd_o),
    .fast_o   (fast_off_o)
  );

  grp_escalate i_esc (
    .clk_i, .rst_ni,
    .stat_i (grp_stat_i),
    .erc_i  (erc),
    .warn_o, .fault_o, .err_o, .fe_en_o, .cb_o
  );

  grp_intr_map i_intr (
    .clk_i, .rst_ni, .int_ni,
    .map_i ({im2, im1}),
    .off_o (int_off_o)
  );
endmodule

// File: rtl/grp_fault_matrix_chk.sv
module grp_fault_matrix_chk
  import grp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     rdata_o,
  input logic              clr_i,
  input logic [NG-1:0]     ok_in_i,
  input logic [NG-1:0]     ok_pd_o,
  input logic [NG-1:0]     fast_off_o,
  input logic              fe_en_o,
  input logic              cb_o,
  input logic [NG-1:0]     int_ni,
  input logic [NG-1:0]     int_off_o
);
  a_r2_rt1_unimpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_RT1) |-> ((rdata_o & ~RT1_MASK) == '0));
  a_r2_rt2_unimpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_RT2) |-> ((rdata_o & ~RT2_MASK) == '0));

  for (genvar t = 0; t < NG; t++) begin : g_t
    a_r5_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ok_pd_o[t] && !clr_i) |=> ok_pd_o[t]);
    a_r4_rise_needs_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ok_pd_o[t]) |-> $past(|(~ok_in_i & ~ok_pd_o)));
  end

  a_r7_fast_in_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_off_o & ~ok_pd_o) == '0);
  a_r8_cb_fe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cb_o |-> !fe_en_o);
  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&int_ni) |=> (int_off_o == '0));
endmodule

bind grp_fault_matrix grp_fault_matrix_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rdata_o(rdata_o),
  .clr_i(clr_i), .ok_in_i(ok_in_i), .ok_pd_o(ok_pd_o),
  .fast_off_o(fast_off_o), .fe_en_o(fe_en_o), .cb_o(cb_o),
  .int_ni(int_ni), .int_off_o(int_off_o)
);

// File: tb/test_grp_fault_matrix.sv
`timescale 1ns/1ps
module test_grp_fault_matrix;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, clr = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [3:0]  ext_pull = 0, ok_in, ok_pd, fast_off, warn, fault, err, int_n = 4'hF, int_off;
  logic [31:0] stat = 32'hFFFF_FFFF;
  logic        fe_en, cb;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  assign ok_in = ~(ok_pd | ext_pull);

  grp_fault_matrix i_grp_fault_matrix (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .clr_i(clr), .ok_in_i(ok_in), .ok_pd_o(ok_pd),
    .fast_off_o(fast_off), .grp_stat_i(stat), .warn_o(warn), .fault_o(fault),
    .err_o(err), .fe_en_o(fe_en), .cb_o(cb), .int_ni(int_n), .int_off_o(int_off)
  );

  // {rt1, rt2, ext source, expected pull-downs}
  localparam logic [23:0] VEC [8] = '{
    {8'h02, 8'h00, 4'b0001, 4'b0010},
    {8'hD0, 8'h00, 4'b0010, 4'b1101},
    {8'h00, 8'h0B, 4'b0100, 4'b1011},
    {8'h00, 8'h70, 4'b1000, 4'b0111},
    {8'hDE, 8'h7B, 4'b0001, 4'b1110},
    {8'h0C, 8'h00, 4'b0010, 4'b0000},
    {8'h21, 8'h84, 4'b0001, 4'b0000},
    {8'h02, 8'h01, 4'b0101, 4'b0011}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, {24'h0, rdata}, {24'h0, exp});
  endtask

  task automatic clr_pulse();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk("R1 reg reset", a[2:0], 8'h00);
    check("R1 pd", {28'h0, ok_pd}, 0);
    check("R1 fast", {28'h0, fast_off}, 0);
    check("R1 fe/cb", {30'h0, fe_en, cb}, 32'h2);
    check("R1 int_off", {28'h0, int_off}, 0);

    // R2 register masks
    wr(3'd0, 8'hFF); rd_chk("R2 rt1 mask", 3'd0, 8'hDE);
    wr(3'd1, 8'hFF); rd_chk("R2 rt2 mask", 3'd1, 8'h7B);
    wr(3'd2, 8'hA5); rd_chk("R2 erc", 3'd2, 8'hA5);
    wr(3'd5, 8'hFF); rd_chk("R2 unused addr", 3'd5, 8'h00);
    rd_chk("R2 rt1 kept", 3'd0, 8'hDE);
    wr(3'd2, 8'h00);

    // R3 routing table
    foreach (VEC[k]) begin
      wr(3'd0, VEC[k][23:16]);
      wr(3'd1, VEC[k][15:8]);
      @(negedge clk); ext_pull = VEC[k][7:4];
      @(negedge clk);
      check($sformatf("R3 vec%0d pd", k), {28'h0, ok_pd}, {28'h0, VEC[k][3:0]});
      check($sformatf("R7 vec%0d no fast", k), {28'h0, fast_off}, 0);
      ext_pull = 0;
      clr_pulse(); clr_pulse();
      check($sformatf("R5 vec%0d cleared", k), {28'h0, ok_pd}, 0);
    end

    // R4 chain A->B->C: B driven by block must not propagate
    wr(3'd0, 8'h42); wr(3'd1, 8'h00);
    @(negedge clk); ext_pull = 4'b0001;
    repeat (4) @(negedge clk);
    check("R4 no chain", {28'h0, ok_pd}, 32'h2);
    // R5 clear blocked while source held low, and without strobe
    clr_pulse();
    check("R5 clr while src low", {28'h0, ok_pd}, 32'h2);
    ext_pull = 0;
    repeat (3) @(negedge clk);
    check("R5 no strobe", {28'h0, ok_pd}, 32'h2);
    clr_pulse();
    check("R5 clear", {28'h0, ok_pd}, 0);

    // R6 classification
    stat = 32'hFFFF_FFFF; #1;
    check("R6 none", {20'h0, warn, fault, err}, 0);
    stat = 32'h7FFF_F7FF; #1;  // D warn, B fault
    check("R6 warn", {28'h0, warn}, 32'h8);
    check("R6 fault", {28'h0, fault}, 32'h2);
    stat = 32'hFEFF_FFFF; #1;  // D phase error
    check("R6 err", {28'h0, err}, 32'h8);
    check("R6 err only", {28'h0, fault | warn}, 0);

    // R7 error-sourced propagation is fast
    stat = 32'hFFFF_FFFD;
    wr(3'd0, 8'h02);
    @(negedge clk); ext_pull = 4'b0001;
    @(negedge clk);
    check("R7 pd", {28'h0, ok_pd}, 32'h2);
    check("R7 fast", {28'h0, fast_off}, 32'h2);
    ext_pull = 0; stat = 32'hFFFF_FFFF;
    clr_pulse();
    check("R7 fast cleared", {28'h0, fast_off}, 0);

    // R8 escalation
    wr(3'd2, 8'h01);
    @(negedge clk); stat = 32'hFFFF_FFFD;
    @(negedge clk);
    check("R8 code01", {30'h0, fe_en, cb}, 32'h0);
    stat = 32'hFFFF_FFFF;
    wr(3'd2, 8'h08);
    @(negedge clk); stat = 32'hFFFF_FEFF;
    @(negedge clk);
    check("R8 code10", {30'h0, fe_en, cb}, 32'h1);
    wr(3'd2, 8'h0C);
    @(negedge clk);
    check("R8 code11", {30'h0, fe_en, cb}, 32'h2);
    wr(3'd2, 8'h00);
    @(negedge clk);
    check("R8 code00", {30'h0, fe_en, cb}, 32'h2);
    wr(3'd2, 8'h08); stat = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R8 no error", {30'h0, fe_en, cb}, 32'h2);

    // R9 interrupt mapping
    wr(3'd3, 8'h92); wr(3'd4, 8'h48);
    @(negedge clk); int_n = 4'b1101;
    @(negedge clk);
    check("R9 int1", {28'h0, int_off}, 32'h9);
    int_n = 4'b1110;
    @(negedge clk);
    check("R9 int0", {28'h0, int_off}, 32'h2);
    int_n = 4'b0111;
    @(negedge clk);
    check("R9 int3", {28'h0, int_off}, 32'h4);
    int_n = 4'b1011;
    @(negedge clk);
    check("R9 int2", {28'h0, int_off}, 32'h8);
    // R10 release
    int_n = 4'hF;
    @(negedge clk);
    check("R10 release", {28'h0, int_off}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule